// File: doc/BRIEF.md
# Frame-Based Dyadic Operand Matcher

This block is the matching stage of a token-driven processing pipeline. Each incoming token carries a frame pointer, an instruction pointer, a port bit (left or right) and a data value. The block first looks up the instruction that the token targets. The instruction supplies an arity bit and a slot offset. The offset is added to the frame pointer, and the sum selects one slot of a directly addressed operand store. No associative search is involved.

A single presence bit per slot decides the outcome of a dyadic instruction. If the first operand is still missing, the block parks the token's value in the slot and emits nothing. If the first operand is already waiting, the block clears the bit, retrieves the waiting value, and hands the ordered operand pair to the execute stage. A monadic instruction skips the slot entirely and passes its operand straight through.

The block is pipelined in three stages: instruction lookup, address generation with the presence operation, and operand store or retrieve with the output register. It accepts one token per cycle. Backpressure from the execute side freezes all three stages. The instruction table is loaded through a simple write port.

Top module: `frame_operand_matcher`

## Requirements
- R1: After reset no output is valid, `in_ready` is high, and every slot's presence bit is clear, so the first dyadic token to any slot produces no output.
- R2: The slot index is `in_fp + offset` modulo 256. Two tokens whose frame pointer and offset differ but whose sums are equal modulo 256 meet in the same slot.
- R3: A dyadic token that finds its slot empty sets the presence bit, stores its value and port, and produces no output.
- R4: A dyadic token that finds its slot occupied produces exactly one output with `out_dyadic`=1 and clears the bit, so the next token to that slot is stored again.
- R5: In a released pair, the operand that arrived with port 0 appears on `out_left` and the operand that arrived with port 1 appears on `out_right`, whichever of the two arrived first.
- R6: A monadic instruction outputs its value on `out_left`, with `out_right`=0 and `out_dyadic`=0, and it leaves every presence bit and stored value untouched.
- R7: `out_fp` and `out_ip` carry the frame pointer and instruction pointer of the token that triggered the output.
- R8: An output becomes valid on the second rising edge after the edge that accepts its triggering token, and one token can be accepted every cycle.
- R9: Tokens to the same slot on consecutive cycles pair correctly. Four such tokens yield two pairs, each pair holding the right values.
- R10: While `out_valid`=1 and `out_ready`=0, the output stays stable, `in_ready` is low, no state changes, and no accepted token is lost or reordered.
- R11: A write with `prog_we`=1 sets entry `prog_addr` to arity `prog_dyadic` (1 = dyadic) and slot offset `prog_offset`. After reset every entry is monadic with offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Token accepted this cycle when high with in_valid |
| in_fp | input | 8 | Frame pointer of the token |
| in_ip | input | 6 | Instruction pointer of the token |
| in_port | input | 1 | Operand position: 0 left, 1 right |
| in_data | input | 16 | Operand value |
| prog_we | input | 1 | Instruction table write enable |
| prog_addr | input | 6 | Instruction table entry to write |
| prog_dyadic | input | 1 | Arity of written entry: 1 dyadic, 0 monadic |
| prog_offset | input | 8 | Slot offset of written entry |
| out_valid | output | 1 | Operands ready for execution |
| out_ready | input | 1 | Execute stage takes the output |
| out_dyadic | output | 1 | 1 for a matched pair, 0 for a monadic pass-through |
| out_left | output | 16 | Left operand |
| out_right | output | 16 | Right operand (0 when monadic) |
| out_fp | output | 8 | Frame pointer of the triggering token |
| out_ip | output | 6 | Instruction pointer of the triggering token |

## Verification
A presence bit left in the wrong state is not visible when it goes wrong. It shows up only at the next token aimed at that slot. A bit left set turns a fresh first operand into a bogus pair. A bit left clear swallows a partner and leaves the output silent. For this reason every scenario sends a follow-up token to the slots it has touched. Because the table entry, the slot address and the stored port bit are all decoded before the output register, errors in them appear as wrong values or wrong left/right order exactly two edges after acceptance.

// File: rtl/fom_pkg.sv
package fom_pkg;

    // Operand position carried by a token and recorded with a parked operand
    typedef enum logic {
        PORT_LEFT  = 1'b0,
        PORT_RIGHT = 1'b1
    } port_e;

    // Arity bit held in each instruction table entry
    typedef enum logic {
        ARITY_MONADIC = 1'b0,
        ARITY_DYADIC  = 1'b1
    } arity_e;

endpackage

// File: rtl/fom_fetch.sv
module fom_fetch #(
    parameter int IP_W   = 6,
    parameter int SLOT_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              in_valid,
    input  logic [SLOT_W-1:0] in_fp,
    input  logic [IP_W-1:0]   in_ip,
    input  logic              in_port,
    input  logic [DATA_W-1:0] in_data,
    input  logic              prog_we,
    input  logic [IP_W-1:0]   prog_addr,
    input  logic              prog_dyadic,
    input  logic [SLOT_W-1:0] prog_offset,
    output logic              s1_valid,
    output logic [SLOT_W-1:0] s1_fp,
    output logic [IP_W-1:0]   s1_ip,
    output logic              s1_port,
    output logic [DATA_W-1:0] s1_data,
    output logic              s1_dyadic,
    output logic [SLOT_W-1:0] s1_offset
);
    import fom_pkg::*;

    localparam int ENTRIES = 1 << IP_W;

    typedef struct packed {
        logic [ENTRIES-1:0]             arity;
        logic [ENTRIES-1:0][SLOT_W-1:0] offset;
        logic                           valid;
        logic [SLOT_W-1:0]              fp;
        logic [IP_W-1:0]                ip;
        logic                           port;
        logic [DATA_W-1:0]              data;
        logic                           dyadic;
        logic [SLOT_W-1:0]              off;
    } fetch_t;

    fetch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // table write; a same-cycle lookup still sees the old entry
        if (prog_we) begin
            st_d.arity[prog_addr]  = prog_dyadic;
            st_d.offset[prog_addr] = prog_offset;
        end
        if (advance) begin
            st_d.valid  = in_valid;
            st_d.fp     = in_fp;
            st_d.ip     = in_ip;
            st_d.port   = in_port;
            st_d.data   = in_data;
            st_d.dyadic = (arity_e'(st_q.arity[in_ip]) == ARITY_DYADIC);
            st_d.off    = st_q.offset[in_ip];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_valid  = st_q.valid;
    assign s1_fp     = st_q.fp;
    assign s1_ip     = st_q.ip;
    assign s1_port   = st_q.port;
    assign s1_data   = st_q.data;
    assign s1_dyadic = st_q.dyadic;
    assign s1_offset = st_q.off;

    // R10: a frozen pipeline keeps its lookup stage unchanged
    assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> (s1_valid == $past(s1_valid)) && $stable(s1_data) && $stable(s1_offset));

endmodule

// File: rtl/fom_presence.sv
module fom_presence #(
    parameter int IP_W   = 6,
    parameter int SLOT_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              s1_valid,
    input  logic [SLOT_W-1:0] s1_fp,
    input  logic [IP_W-1:0]   s1_ip,
    input  logic              s1_port,
    input  logic [DATA_W-1:0] s1_data,
    input  logic              s1_dyadic,
    input  logic [SLOT_W-1:0] s1_offset,
    output logic              s2_valid,
    output logic [SLOT_W-1:0] s2_fp,
    output logic [IP_W-1:0]   s2_ip,
    output logic              s2_port,
    output logic [DATA_W-1:0] s2_data,
    output logic              s2_dyadic,
    output logic [SLOT_W-1:0] s2_addr,
    output logic              s2_match
);
    localparam int SLOTS = 1 << SLOT_W;

    typedef struct packed {
        logic [SLOTS-1:0]  present;
        logic              valid;
        logic [SLOT_W-1:0] fp;
        logic [IP_W-1:0]   ip;
        logic              port;
        logic [DATA_W-1:0] data;
        logic              dyadic;
        logic [SLOT_W-1:0] addr;
        logic              match;
    } pres_t;

    pres_t st_d, st_q;
    logic [SLOT_W-1:0] slot_addr;

    // address generation: wraps modulo the slot count
    assign slot_addr = s1_fp + s1_offset;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            // presence read-modify-write completes here, so a following
            // token to the same slot always sees this token's effect
            if (s1_valid && s1_dyadic) begin
                st_d.present[slot_addr] = !st_q.present[slot_addr];
            end
            st_d.valid  = s1_valid;
            st_d.fp     = s1_fp;
            st_d.ip     = s1_ip;
            st_d.port   = s1_port;
            st_d.data   = s1_data;
            st_d.dyadic = s1_dyadic;
            st_d.addr   = slot_addr;
            st_d.match  = st_q.present[slot_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s2_valid  = st_q.valid;
    assign s2_fp     = st_q.fp;
    assign s2_ip     = st_q.ip;
    assign s2_port   = st_q.port;
    assign s2_data   = st_q.data;
    assign s2_dyadic = st_q.dyadic;
    assign s2_addr   = st_q.addr;
    assign s2_match  = st_q.match;

    // R3: an empty slot becomes occupied by a first operand
    assert_first_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && s1_valid && s1_dyadic && !st_q.present[slot_addr])
        |=> st_q.present[$past(slot_addr)]);

    // R4: an occupied slot is emptied by its partner
    assert_pair_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && s1_valid && s1_dyadic && st_q.present[slot_addr])
        |=> !st_q.present[$past(slot_addr)]);

    // R6: monadic traffic leaves all presence bits alone
    assert_monadic_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && s1_valid && !s1_dyadic) |=> $stable(st_q.present));

    // R10: nothing changes while the output is blocked
    assert_stall_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(st_q.present));

endmodule

// File: rtl/fom_frame.sv
module fom_frame #(
    parameter int IP_W   = 6,
    parameter int SLOT_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s2_valid,
    input  logic [SLOT_W-1:0] s2_fp,
    input  logic [IP_W-1:0]   s2_ip,
    input  logic              s2_port,
    input  logic [DATA_W-1:0] s2_data,
    input  logic              s2_dyadic,
    input  logic [SLOT_W-1:0] s2_addr,
    input  logic              s2_match,
    input  logic              out_ready,
    output logic              advance,
    output logic              out_valid,
    output logic              out_dyadic,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic [SLOT_W-1:0] out_fp,
    output logic [IP_W-1:0]   out_ip
);
    import fom_pkg::*;

    localparam int SLOTS = 1 << SLOT_W;

    typedef struct packed {
        logic              valid;
        logic              dyadic;
        logic [DATA_W-1:0] left;
        logic [DATA_W-1:0] right;
        logic [SLOT_W-1:0] fp;
        logic [IP_W-1:0]   ip;
    } out_t;

    out_t st_d, st_q;

    // operand store: value plus the port it arrived on, gated by presence bits
    logic [DATA_W-1:0] slot_val [SLOTS];
    logic              slot_port[SLOTS];

    logic [DATA_W-1:0] parked_val;
    logic              parked_port;
    logic              park_we;

    assign advance     = !(st_q.valid && !out_ready);
    assign parked_val  = slot_val[s2_addr];
    assign parked_port = slot_port[s2_addr];
    assign park_we     = advance && s2_valid && s2_dyadic && !s2_match;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.valid  = s2_valid && (!s2_dyadic || s2_match);
            st_d.dyadic = s2_dyadic;
            st_d.fp     = s2_fp;
            st_d.ip     = s2_ip;
            if (!s2_dyadic) begin
                st_d.left  = s2_data;
                st_d.right = '0;
            end else if (port_e'(parked_port) == PORT_LEFT) begin
                st_d.left  = parked_val;
                st_d.right = s2_data;
            end else begin
                st_d.left  = s2_data;
                st_d.right = parked_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (park_we) begin
            slot_val[s2_addr]  <= s2_data;
            slot_port[s2_addr] <= s2_port;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_dyadic = st_q.dyadic;
    assign out_left   = st_q.left;
    assign out_right  = st_q.right;
    assign out_fp     = st_q.fp;
    assign out_ip     = st_q.ip;

    // R10: a blocked output holds
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_left)
                                      && $stable(out_right) && $stable(out_ip));

    // R4: a matched slot always yields an output pair
    assert_pair_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && s2_valid && s2_dyadic && s2_match) |=> out_valid && out_dyadic);

    // R3: parking a first operand is silent
    assert_first_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        park_we |=> !out_valid);

    // R6: monadic output carries nothing on the right
    assert_monadic_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_dyadic) |-> (out_right == '0));

endmodule

// File: rtl/frame_operand_matcher.sv
module frame_operand_matcher #(
    parameter int IP_W   = 6,
    parameter int SLOT_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SLOT_W-1:0] in_fp,
    input  logic [IP_W-1:0]   in_ip,
    input  logic              in_port,
    input  logic [DATA_W-1:0] in_data,
    input  logic              prog_we,
    input  logic [IP_W-1:0]   prog_addr,
    input  logic              prog_dyadic,
    input  logic [SLOT_W-1:0] prog_offset,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_dyadic,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic [SLOT_W-1:0] out_fp,
    output logic [IP_W-1:0]   out_ip
);
    logic              advance;

    logic              s1_valid, s1_port, s1_dyadic;
    logic [SLOT_W-1:0] s1_fp, s1_offset;
    logic [IP_W-1:0]   s1_ip;
    logic [DATA_W-1:0] s1_data;

    logic              s2_valid, s2_port, s2_dyadic, s2_match;
    logic [SLOT_W-1:0] s2_fp, s2_addr;
    logic [IP_W-1:0]   s2_ip;
    logic [DATA_W-1:0] s2_data;

    assign in_ready = advance;

    fom_fetch #(.IP_W(IP_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .advance(advance),
        .in_valid(in_valid), .in_fp(in_fp), .in_ip(in_ip),
        .in_port(in_port), .in_data(in_data),
        .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_dyadic(prog_dyadic), .prog_offset(prog_offset),
        .s1_valid(s1_valid), .s1_fp(s1_fp), .s1_ip(s1_ip), .s1_port(s1_port),
        .s1_data(s1_data), .s1_dyadic(s1_dyadic), .s1_offset(s1_offset)
    );

    fom_presence #(.IP_W(IP_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_presence (
        .clk(clk), .rst_n(rst_n), .advance(advance),
        .s1_valid(s1_valid), .s1_fp(s1_fp), .s1_ip(s1_ip), .s1_port(s1_port),
        .s1_data(s1_data), .s1_dyadic(s1_dyadic), .s1_offset(s1_offset),
        .s2_valid(s2_valid), .s2_fp(s2_fp), .s2_ip(s2_ip), .s2_port(s2_port),
        .s2_data(s2_data), .s2_dyadic(s2_dyadic), .s2_addr(s2_addr),
        .s2_match(s2_match)
    );

    fom_frame #(.IP_W(IP_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .s2_valid(s2_valid), .s2_fp(s2_fp), .s2_ip(s2_ip), .s2_port(s2_port),
        .s2_data(s2_data), .s2_dyadic(s2_dyadic), .s2_addr(s2_addr),
        .s2_match(s2_match), .out_ready(out_ready), .advance(advance),
        .out_valid(out_valid), .out_dyadic(out_dyadic), .out_left(out_left),
        .out_right(out_right), .out_fp(out_fp), .out_ip(out_ip)
    );

    // R10: backpressure is reflected at the input
    assert_stall_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $past(in_ready) == 1'b0 || !$past(out_valid));

endmodule

// File: tb/tb_frame_operand_matcher.sv
module tb_frame_operand_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_port = 1'b0;
    logic        in_ready;
    logic [7:0]  in_fp = '0;
    logic [5:0]  in_ip = '0;
    logic [15:0] in_data = '0;
    logic        prog_we = 1'b0, prog_dyadic = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [7:0]  prog_offset = '0;
    logic        out_valid, out_dyadic;
    logic        out_ready = 1'b1;
    logic [15:0] out_left, out_right;
    logic [7:0]  out_fp;
    logic [5:0]  out_ip;

    int n_chk = 0, n_fail = 0, cyc = 0, ncap = 0;
    logic [15:0] cap_l[64], cap_r[64];
    logic        cap_dy[64];
    logic [7:0]  cap_fp[64];
    logic [5:0]  cap_ip[64];
    int          cap_cyc[64];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frame_operand_matcher dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_fp(in_fp), .in_ip(in_ip), .in_port(in_port), .in_data(in_data),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_dyadic(prog_dyadic),
        .prog_offset(prog_offset), .out_valid(out_valid), .out_ready(out_ready),
        .out_dyadic(out_dyadic), .out_left(out_left), .out_right(out_right),
        .out_fp(out_fp), .out_ip(out_ip)
    );

    // capture every handshaken output, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && ncap < 64) begin
            cap_l[ncap]   = out_left;
            cap_r[ncap]   = out_right;
            cap_dy[ncap]  = out_dyadic;
            cap_fp[ncap]  = out_fp;
            cap_ip[ncap]  = out_ip;
            cap_cyc[ncap] = cyc;
            ncap++;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic program_entry(input logic [5:0] a, input logic dy, input logic [7:0] off);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = a; prog_dyadic = dy; prog_offset = off;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] fp, input logic [5:0] ip, input logic port,
                        input logic [15:0] d, output int acc);
        @(negedge clk);
        in_valid = 1'b1; in_fp = fp; in_ip = ip; in_port = port; in_data = d;
        while (!in_ready) @(negedge clk);
        acc = cyc + 1;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
        #1;
    endtask

    task automatic chk_pair(input string req, input int idx, input logic dy,
                            input logic [15:0] l, input logic [15:0] r);
        chk(req, "dyadic flag", 32'(cap_dy[idx]), 32'(dy));
        chk(req, "left", 32'(cap_l[idx]), 32'(l));
        chk(req, "right", 32'(cap_r[idx]), 32'(r));
    endtask

    task automatic test_reset();
        int a, base;
        chk("R1", "out_valid after reset", 32'(out_valid), 32'd0);
        chk("R1", "in_ready after reset", 32'(in_ready), 32'd1);
        // R11: an unwritten entry is monadic with offset 0
        base = ncap;
        send(8'h11, 6'd7, 1'b1, 16'h1234, a);
        idle(6);
        chk("R11", "unwritten entry passes through", 32'(ncap - base), 32'd1);
        chk_pair("R11", base, 1'b0, 16'h1234, 16'h0000);
    endtask

    task automatic test_basic_pair();
        int a, base;
        base = ncap;
        send(8'h20, 6'd1, 1'b0, 16'hAAAA, a);
        idle(6);
        chk("R3", "first operand silent", 32'(ncap - base), 32'd0);
        send(8'h20, 6'd1, 1'b1, 16'hBBBB, a);
        idle(6);
        chk("R4", "pair released", 32'(ncap - base), 32'd1);
        chk_pair("R4", base, 1'b1, 16'hAAAA, 16'hBBBB);
        chk("R7", "out_fp", 32'(cap_fp[base]), 32'h20);
        chk("R7", "out_ip", 32'(cap_ip[base]), 32'd1);
        chk("R8", "latency", 32'(cap_cyc[base] - a), 32'd2);
    endtask

    task automatic test_port_order();
        int a, base;
        base = ncap;
        send(8'h30, 6'd1, 1'b1, 16'h1111, a);
        send(8'h30, 6'd1, 1'b0, 16'h2222, a);
        idle(6);
        chk("R5", "reverse arrival count", 32'(ncap - base), 32'd1);
        chk_pair("R5", base, 1'b1, 16'h2222, 16'h1111);
    endtask

    task automatic test_wrap_addr();
        int a, base;
        base = ncap;
        // 0xF8 + 0x10 wraps to 0x08, as does 0x03 + 0x05
        send(8'hF8, 6'd3, 1'b0, 16'h0303, a);
        send(8'h03, 6'd1, 1'b1, 16'h0404, a);
        idle(6);
        chk("R2", "wrapped slots meet", 32'(ncap - base), 32'd1);
        chk_pair("R2", base, 1'b1, 16'h0303, 16'h0404);
        chk("R7", "out_fp of partner", 32'(cap_fp[base]), 32'h03);
    endtask

    task automatic test_monadic();
        int a, base;
        base = ncap;
        send(8'h40, 6'd1, 1'b0, 16'h5555, a);
        send(8'h40, 6'd2, 1'b1, 16'h6666, a);
        send(8'h40, 6'd1, 1'b1, 16'h7777, a);
        idle(6);
        chk("R6", "output count", 32'(ncap - base), 32'd2);
        chk_pair("R6", base, 1'b0, 16'h6666, 16'h0000);
        chk_pair("R6", base + 1, 1'b1, 16'h5555, 16'h7777);
    endtask

    task automatic test_burst();
        int a1, a2, a3, a4, base;
        base = ncap;
        send(8'h50, 6'd4, 1'b0, 16'h0001, a1);
        send(8'h50, 6'd4, 1'b1, 16'h0002, a2);
        send(8'h50, 6'd4, 1'b1, 16'h0003, a3);
        send(8'h50, 6'd4, 1'b0, 16'h0004, a4);
        idle(6);
        chk("R9", "two pairs", 32'(ncap - base), 32'd2);
        chk_pair("R9", base, 1'b1, 16'h0001, 16'h0002);
        chk_pair("R9", base + 1, 1'b1, 16'h0004, 16'h0003);
        chk("R8", "burst accepted every cycle", 32'(a4 - a1), 32'd3);
        chk("R8", "second pair latency", 32'(cap_cyc[base + 1] - a4), 32'd2);
    endtask

    task automatic test_stall();
        int a, base;
        base = ncap;
        @(posedge clk); #2;
        out_ready = 1'b0;
        send(8'h60, 6'd2, 1'b0, 16'h00A1, a);
        send(8'h60, 6'd2, 1'b0, 16'h00A2, a);
        send(8'h60, 6'd2, 1'b0, 16'h00A3, a);
        idle(5);
        chk("R10", "in_ready low while blocked", 32'(in_ready), 32'd0);
        chk("R10", "out_valid held", 32'(out_valid), 32'd1);
        chk("R10", "held value", 32'(out_left), 32'h00A1);
        @(posedge clk); #2;
        out_ready = 1'b1;
        idle(6);
        chk("R10", "none lost", 32'(ncap - base), 32'd3);
        chk("R10", "order 1", 32'(cap_l[base]), 32'h00A1);
        chk("R10", "order 2", 32'(cap_l[base + 1]), 32'h00A2);
        chk("R10", "order 3", 32'(cap_l[base + 2]), 32'h00A3);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        test_reset();
        program_entry(6'd1, 1'b1, 8'h05);
        program_entry(6'd2, 1'b0, 8'h05);
        program_entry(6'd3, 1'b1, 8'h10);
        program_entry(6'd4, 1'b1, 8'h00);
        test_basic_pair();
        test_port_order();
        test_wrap_addr();
        test_monadic();
        test_burst();
        test_stall();
        report();
        $finish;
    end

endmodule